// File: doc/BRIEF.md
# Programmable Parallel Port with Port-C Bit Commands

This block sits on a processor's byte-wide register bus and provides three general-purpose ports. Two are full bytes, called A and B. The third, C, is split into an upper and a lower nibble. Software sets each port's direction through one write-only control register. A control write with bit 7 high defines the mode. A control write with bit 7 low is a one-bit set/reset command for port C. That command touches only the selected port C latch bit and leaves the current mode alone, so the control address can also drive single handshake and interrupt-enable lines.

In simple mode, each port or nibble is an output latch or a direct input. In strobed mode, port A and/or port B use fixed port C pins for strobe, buffer-full and interrupt lines. The byte port then holds its data in a register in either direction. A group A mode code with bit 6 set requests bidirectional operation. That operation is not built: the block raises a flag and runs port A as in simple mode. All bus inputs and pins are taken as synchronous to `clk`. Read data is registered, so it appears, together with its enable, in the cycle after the read.

Top module: `pio_port`

## Requirements
- R1: After a synchronous reset, the control state is 0x9B: every port is a simple-mode input, so `pa_oe`, `pb_oe` and `pc_oe` are 0, all output latches are 0, `rdata_oe` is 0 and `mode2_flag` is 0.
- R2: A control write (addr 3) with bit 7 = 1 sets the directions, where 1 means input. Bit 4 is port A, bit 3 is port C bits 7:4, bit 1 is port B and bit 0 is port C bits 3:0. `pa_oe`, `pb_oe` and `pc_oe` show the result in the next cycle.
- R3: In simple mode, a write to addr 0, 1 or 2 stores the byte in that port's output latch. The latch appears on the port's output pins in the next cycle. A read of an output port returns the latch.
- R4: A read (`cs` and `rd` high, `wr` low) places data on `rdata` and raises `rdata_oe` in the next cycle. In any other cycle, `rdata_oe` is low in the cycle after. A simple-mode input read returns the pin value present at the read's clock edge.
- R5: A control write with bit 7 = 0 sets or clears one port C latch bit. Bits 3:1 give the bit index and bit 0 gives the new value. Directions, modes and the port A and B latches are unchanged.
- R6: A mode-definition write clears the A, B and C output latches and all handshake flags.
- R7: A read of the control address returns 0x00.
- R8: With group A in strobed input mode (bits 6:5 = 01, bit 4 = 1), PC4 low latches `pa_in` and drives input-full PC5 high. A port A read returns the latched byte and clears PC5.
- R9: In strobed mode, a rising edge of the strobe (input) or acknowledge (output) line sets the interrupt line if the enable is on. For group A the interrupt is PC3 and the enable is the PC4 latch bit (input) or the PC6 latch bit (output). For group B the interrupt is PC0 and the enable is the PC2 latch bit. With the enable off, the interrupt stays low.
- R10: With group A in strobed output mode, a port A write drives PC7 (output-full, active low) low and clears the interrupt. PC6 (acknowledge, active low) low drives PC7 high again.
- R11: With group B in strobed mode (bit 2 = 1), PC2 is the strobe or acknowledge input and PC1 is input-full (active high) or output-full (active low). Strobed input latches `pb_in`, and a port B read returns it and clears PC1 and PC0.
- R12: A group A mode field with bit 6 = 1 raises `mode2_flag`, and port A then acts as a simple-mode port.
- R13: In strobed mode, the handshake pins have fixed directions: group A drives PC3 and PC5 (input) or PC3 and PC7 (output), and samples PC4 or PC6. Group B drives PC0 and PC1 and samples PC2. The other port C pins keep their nibble direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select |
| rd | input | 1 | Read request |
| wr | input | 1 | Write request |
| addr | input | 2 | Register select: 0 A, 1 B, 2 C, 3 control |
| wdata | input | DW | Write data |
| rdata | output | DW | Registered read data |
| rdata_oe | output | 1 | High in the cycle read data is valid |
| pa_in | input | DW | Port A pin input |
| pa_out | output | DW | Port A output value |
| pa_oe | output | DW | Port A drive enable per bit |
| pb_in | input | DW | Port B pin input |
| pb_out | output | DW | Port B output value |
| pb_oe | output | DW | Port B drive enable per bit |
| pc_in | input | DW | Port C pin input |
| pc_out | output | DW | Port C output value |
| pc_oe | output | DW | Port C drive enable per bit |
| mode2_flag | output | 1 | Bidirectional mode requested, not supported |

## Verification
The properties assume that `rd` and `wr` are never high together with `cs`. They also assume that every pin, including strobes and acknowledges, changes only between clock edges, because no synchronizer is present. The bench drives every bus and pin input at the falling clock edge and never raises `rd` and `wr` together. A strobe or acknowledge pulse is held low for exactly one rising edge, so the edge detector sees one clean fall and one clean rise.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int DW = 8;
  localparam int NIB = DW / 2;

  localparam logic [1:0] SEL_A = 2'd0;
  localparam logic [1:0] SEL_B = 2'd1;
  localparam logic [1:0] SEL_C = 2'd2;
  localparam logic [1:0] SEL_CTL = 2'd3;

  localparam logic [7:0] CTL_RESET = 8'h9B;

  // Port C pin roles in strobed mode
  localparam int PC_A_INTR = 3;
  localparam int PC_A_STB = 4;
  localparam int PC_A_IFULL = 5;
  localparam int PC_A_ACK = 6;
  localparam int PC_A_OFULL = 7;
  localparam int PC_B_INTR = 0;
  localparam int PC_B_FLAG = 1;
  localparam int PC_B_HS = 2;

  // Bit layout of the mode word; the order is decoded by the block
  typedef struct packed {
    logic is_mode;
    logic [1:0] a_mode;
    logic a_in;
    logic cu_in;
    logic b_mode;
    logic b_in;
    logic cl_in;
  } pio_ctl_t;
endpackage

// File: rtl/pio_hs_chan.sv
module pio_hs_chan #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          active,
  input  logic          is_in,
  input  logic          pin_n,
  input  logic          inte,
  input  logic [DW-1:0] din,
  input  logic          rd_hit,
  input  logic          wr_hit,
  output logic [DW-1:0] dout,
  output logic          full,
  output logic          intr
);
  logic pin_q;
  logic intr_q;
  logic rise;

  assign rise = !pin_q && pin_n;

  always_ff @(posedge clk) begin
    if (rst || clear || !active) begin
      dout   <= '0;
      full   <= 1'b0;
      intr_q <= 1'b0;
      pin_q  <= 1'b1;
    end else begin
      pin_q <= pin_n;
      if (is_in) begin
        if (!pin_n) begin
          dout <= din;
          full <= 1'b1;
        end else if (rd_hit) begin
          full <= 1'b0;
        end
        if (rise && inte) intr_q <= 1'b1;
        else if (rd_hit) intr_q <= 1'b0;
      end else begin
        if (wr_hit) full <= 1'b1;
        else if (!pin_n) full <= 1'b0;
        if (wr_hit) intr_q <= 1'b0;
        else if (rise && inte) intr_q <= 1'b1;
      end
    end
  end

  assign intr = intr_q & inte;
endmodule

// File: rtl/pio_pin_map.sv
module pio_pin_map
  import pio_pkg::*;
#(
  parameter int W = 8
) (
  input  pio_ctl_t       ctl,
  input  logic [W-1:0]   pc_lat,
  input  logic [W-1:0]   pc_in,
  input  logic           a_full,
  input  logic           a_intr,
  input  logic           b_full,
  input  logic           b_intr,
  output logic           a_m1,
  output logic           b_m1,
  output logic           a_pin_n,
  output logic           a_inte,
  output logic           b_pin_n,
  output logic           b_inte,
  output logic [W-1:0]   pc_drv,
  output logic [W-1:0]   pc_en,
  output logic [W-1:0]   pc_view
);
  localparam int H = W / 2;

  assign a_m1    = (ctl.a_mode == 2'b01);
  assign b_m1    = ctl.b_mode;
  assign a_pin_n = ctl.a_in ? pc_in[PC_A_STB] : pc_in[PC_A_ACK];
  assign a_inte  = ctl.a_in ? pc_lat[PC_A_STB] : pc_lat[PC_A_ACK];
  assign b_pin_n = pc_in[PC_B_HS];
  assign b_inte  = pc_lat[PC_B_HS];

  always_comb begin
    pc_en  = {{(W-H){~ctl.cu_in}}, {H{~ctl.cl_in}}};
    pc_drv = pc_lat;
    if (a_m1) begin
      pc_en[PC_A_INTR]  = 1'b1;
      pc_drv[PC_A_INTR] = a_intr;
      if (ctl.a_in) begin
        pc_en[PC_A_STB]    = 1'b0;
        pc_en[PC_A_IFULL]  = 1'b1;
        pc_drv[PC_A_IFULL] = a_full;
      end else begin
        pc_en[PC_A_ACK]    = 1'b0;
        pc_en[PC_A_OFULL]  = 1'b1;
        pc_drv[PC_A_OFULL] = ~a_full;
      end
    end
    if (b_m1) begin
      pc_en[PC_B_HS]    = 1'b0;
      pc_en[PC_B_FLAG]  = 1'b1;
      pc_en[PC_B_INTR]  = 1'b1;
      pc_drv[PC_B_INTR] = b_intr;
      pc_drv[PC_B_FLAG] = ctl.b_in ? b_full : ~b_full;
    end
  end

  always_comb begin
    for (int i = 0; i < W; i++) begin
      pc_view[i] = pc_en[i] ? pc_drv[i] : pc_in[i];
    end
  end
endmodule

// File: rtl/pio_port.sv
module pio_port
  import pio_pkg::*;
#(
  parameter int DW = pio_pkg::DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs,
  input  logic          rd,
  input  logic          wr,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          rdata_oe,
  input  logic [DW-1:0] pa_in,
  output logic [DW-1:0] pa_out,
  output logic [DW-1:0] pa_oe,
  input  logic [DW-1:0] pb_in,
  output logic [DW-1:0] pb_out,
  output logic [DW-1:0] pb_oe,
  input  logic [DW-1:0] pc_in,
  output logic [DW-1:0] pc_out,
  output logic [DW-1:0] pc_oe,
  output logic          mode2_flag
);
  localparam int BW = $clog2(DW);

  logic [7:0]    ctl_q;
  pio_ctl_t      ctl;
  logic [DW-1:0] pa_lat, pb_lat, pc_lat;
  logic          wr_hit, rd_hit, mode_wr, bsr_wr;
  logic          a_m1, b_m1, a_pin_n, b_pin_n, a_inte, b_inte;
  logic          a_full, b_full, a_intr, b_intr;
  logic [DW-1:0] a_hold, b_hold, pc_view;
  logic [DW-1:0] rd_mux;
  logic [BW-1:0] bsr_idx;

  assign ctl     = pio_ctl_t'(ctl_q);
  assign wr_hit  = cs && wr;
  assign rd_hit  = cs && rd && !wr;
  assign mode_wr = wr_hit && (addr == SEL_CTL) && wdata[7];
  assign bsr_wr  = wr_hit && (addr == SEL_CTL) && !wdata[7];
  assign bsr_idx = wdata[BW:1];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q  <= CTL_RESET;
      pa_lat <= '0;
      pb_lat <= '0;
      pc_lat <= '0;
    end else if (mode_wr) begin
      ctl_q  <= wdata[7:0];
      pa_lat <= '0;
      pb_lat <= '0;
      pc_lat <= '0;
    end else if (bsr_wr) begin
      pc_lat[bsr_idx] <= wdata[0];
    end else if (wr_hit) begin
      case (addr)
        SEL_A:   pa_lat <= wdata;
        SEL_B:   pb_lat <= wdata;
        SEL_C:   pc_lat <= wdata;
        default: ;
      endcase
    end
  end

  pio_pin_map #(.W(DW)) u_map (
    .ctl(ctl), .pc_lat(pc_lat), .pc_in(pc_in),
    .a_full(a_full), .a_intr(a_intr), .b_full(b_full), .b_intr(b_intr),
    .a_m1(a_m1), .b_m1(b_m1),
    .a_pin_n(a_pin_n), .a_inte(a_inte), .b_pin_n(b_pin_n), .b_inte(b_inte),
    .pc_drv(pc_out), .pc_en(pc_oe), .pc_view(pc_view)
  );

  pio_hs_chan #(.DW(DW)) u_chan_a (
    .clk(clk), .rst(rst), .clear(mode_wr), .active(a_m1), .is_in(ctl.a_in),
    .pin_n(a_pin_n), .inte(a_inte), .din(pa_in),
    .rd_hit(rd_hit && addr == SEL_A), .wr_hit(wr_hit && addr == SEL_A),
    .dout(a_hold), .full(a_full), .intr(a_intr)
  );

  pio_hs_chan #(.DW(DW)) u_chan_b (
    .clk(clk), .rst(rst), .clear(mode_wr), .active(b_m1), .is_in(ctl.b_in),
    .pin_n(b_pin_n), .inte(b_inte), .din(pb_in),
    .rd_hit(rd_hit && addr == SEL_B), .wr_hit(wr_hit && addr == SEL_B),
    .dout(b_hold), .full(b_full), .intr(b_intr)
  );

  always_comb begin
    case (addr)
      SEL_A:   rd_mux = !ctl.a_in ? pa_lat : (a_m1 ? a_hold : pa_in);
      SEL_B:   rd_mux = !ctl.b_in ? pb_lat : (b_m1 ? b_hold : pb_in);
      SEL_C:   rd_mux = pc_view;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata    <= '0;
      rdata_oe <= 1'b0;
    end else begin
      rdata    <= rd_hit ? rd_mux : '0;
      rdata_oe <= rd_hit;
    end
  end

  assign pa_out     = pa_lat;
  assign pb_out     = pb_lat;
  assign pa_oe      = {DW{~ctl.a_in}};
  assign pb_oe      = {DW{~ctl.b_in}};
  assign mode2_flag = ctl.is_mode & ctl.a_mode[1];
endmodule

// File: rtl/pio_port_chk.sv
module pio_port_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          cs,
  input logic          rd,
  input logic          wr,
  input logic [1:0]    addr,
  input logic [DW-1:0] wdata,
  input logic [DW-1:0] rdata,
  input logic          rdata_oe,
  input logic [DW-1:0] pa_out,
  input logic [DW-1:0] pa_oe,
  input logic [DW-1:0] pb_out,
  input logic [DW-1:0] pb_oe,
  input logic [DW-1:0] pc_in,
  input logic [DW-1:0] pc_out,
  input logic          mode2_flag,
  input logic [7:0]    ctl_q
);
  p_rd_oe_r4: assert property (@(posedge clk) disable iff (rst)
    (cs && rd && !wr) |=> rdata_oe);

  p_idle_oe_r4: assert property (@(posedge clk) disable iff (rst)
    !(cs && rd && !wr) |=> !rdata_oe);

  p_ctl_rd_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (cs && rd && !wr && addr == 2'd3) |=> (rdata == '0));

  p_latch_a_r3: assert property (@(posedge clk) disable iff (rst)
    (cs && wr && addr == 2'd0) |=> (pa_out == $past(wdata)));

  p_bsr_keeps_dir_r5: assert property (@(posedge clk) disable iff (rst)
    (cs && wr && addr == 2'd3 && !wdata[7]) |=>
      (pa_oe == $past(pa_oe) && pb_oe == $past(pb_oe) && pa_out == $past(pa_out)));

  p_mode_clears_r6: assert property (@(posedge clk) disable iff (rst)
    (cs && wr && addr == 2'd3 && wdata[7]) |=> (pa_out == '0 && pb_out == '0));

  p_ifull_a_r8: assert property (@(posedge clk) disable iff (rst)
    (!(cs && wr) && ctl_q[6:4] == 3'b011 && !pc_in[4]) |=> pc_out[5]);

  p_mode2_flag_r12: assert property (@(posedge clk) disable iff (rst)
    (cs && wr && addr == 2'd3 && wdata[7:6] == 2'b11) |=> mode2_flag);
endmodule

bind pio_port pio_port_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .cs(cs), .rd(rd), .wr(wr), .addr(addr), .wdata(wdata),
  .rdata(rdata), .rdata_oe(rdata_oe), .pa_out(pa_out), .pa_oe(pa_oe),
  .pb_out(pb_out), .pb_oe(pb_oe), .pc_in(pc_in), .pc_out(pc_out),
  .mode2_flag(mode2_flag), .ctl_q(ctl_q)
);

// File: tb/pio_port_test.sv
module pio_port_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata, pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;
  logic       rdata_oe, mode2_flag;
  logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'hFF;
  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  pio_port uut (
    .clk(clk), .rst(rst), .cs(cs), .rd(rd), .wr(wr), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rdata_oe(rdata_oe),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe),
    .mode2_flag(mode2_flag)
  );

  // {is_read, addr, data, pin, expected read}
  localparam int NV = 19;
  localparam logic [26:0] VEC [0:NV-1] = '{
    {1'b0, 2'd3, 8'h80, 8'hFF, 8'h00},  // R2 all outputs
    {1'b0, 2'd0, 8'hA5, 8'hFF, 8'h00},
    {1'b1, 2'd0, 8'h00, 8'h00, 8'hA5},  // R3 readback A
    {1'b0, 2'd1, 8'h3C, 8'hFF, 8'h00},
    {1'b1, 2'd1, 8'h00, 8'h00, 8'h3C},  // R3 readback B
    {1'b0, 2'd2, 8'h00, 8'hFF, 8'h00},
    {1'b0, 2'd3, 8'h0F, 8'hFF, 8'h00},  // R5 set bit 7
    {1'b1, 2'd2, 8'h00, 8'h00, 8'h80},
    {1'b0, 2'd3, 8'h07, 8'hFF, 8'h00},  // R5 set bit 3
    {1'b1, 2'd2, 8'h00, 8'h00, 8'h88},
    {1'b0, 2'd3, 8'h0E, 8'hFF, 8'h00},  // R5 clear bit 7
    {1'b1, 2'd2, 8'h00, 8'h00, 8'h08},
    {1'b1, 2'd3, 8'h00, 8'h00, 8'h00},  // R7
    {1'b0, 2'd3, 8'h9B, 8'hFF, 8'h00},  // all inputs
    {1'b1, 2'd0, 8'h00, 8'h5A, 8'h5A},  // R4 direct A
    {1'b1, 2'd1, 8'h00, 8'h5A, 8'hA5},  // R4 direct B
    {1'b1, 2'd2, 8'h00, 8'hC3, 8'hC3},  // R4 direct C
    {1'b0, 2'd3, 8'h8A, 8'hFF, 8'h00},  // R2 mixed nibbles
    {1'b0, 2'd2, 8'hFF, 8'hFF, 8'h00}
  };

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    cs = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d, output logic oe);
    @(negedge clk);
    cs = 1'b1; rd = 1'b1; addr = a;
    @(negedge clk);
    cs = 1'b0; rd = 1'b0;
    d = rdata; oe = rdata_oe;
  endtask

  task automatic pulse_pc(input int idx);
    @(negedge clk);
    pc_in[idx] = 1'b0;
    @(negedge clk);
    pc_in[idx] = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog got=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic oe;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 pa_oe", pa_oe, 8'h00);
    chk("R1 pb_oe", pb_oe, 8'h00);
    chk("R1 pc_oe", pc_oe, 8'h00);
    chk("R1 pa_out", pa_out, 8'h00);
    chk("R1 flags", {6'd0, rdata_oe, mode2_flag}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      pa_in = VEC[i][15:8];
      pb_in = ~VEC[i][15:8];
      pc_in = VEC[i][15:8];
      if (VEC[i][26]) begin
        bus_rd(VEC[i][25:24], d, oe);
        chk($sformatf("R4 vec%0d oe", i), {7'd0, oe}, 8'h01);
        chk($sformatf("R3/R4/R5/R7 vec%0d data", i), d, VEC[i][7:0]);
      end else begin
        bus_wr(VEC[i][25:24], VEC[i][23:16]);
      end
    end
    pc_in = 8'h00;
    bus_rd(2'd2, d, oe);
    chk("R2 mixed nibble read", d, 8'h0F);
    chk("R2 mixed pc_oe", pc_oe, 8'h0F);
    @(negedge clk);
    chk("R4 oe drops", {7'd0, rdata_oe}, 8'h00);

    // R2/R3/R5/R6 at the pins
    pc_in = 8'hFF;
    bus_wr(2'd3, 8'h80);
    chk("R2 pa_oe out", pa_oe, 8'hFF);
    chk("R2 pc_oe out", pc_oe, 8'hFF);
    bus_wr(2'd0, 8'h11);
    chk("R3 pa_out", pa_out, 8'h11);
    bus_wr(2'd3, 8'h07);
    chk("R5 pa_oe kept", pa_oe, 8'hFF);
    chk("R5 pa_out kept", pa_out, 8'h11);
    chk("R5 pc bit", pc_out, 8'h08);
    bus_wr(2'd3, 8'h80);
    chk("R6 pa_out cleared", pa_out, 8'h00);
    chk("R6 pc_out cleared", pc_out, 8'h00);

    // Group A strobed input
    bus_wr(2'd3, 8'hB0);
    chk("R13 A in pc_oe", pc_oe, 8'hEF);
    bus_wr(2'd3, 8'h09);
    pa_in = 8'h77;
    pulse_pc(4);
    pa_in = 8'h00;
    chk("R8 ibf set", {7'd0, pc_out[5]}, 8'h01);
    chk("R9 intr A set", {7'd0, pc_out[3]}, 8'h01);
    bus_rd(2'd0, d, oe);
    chk("R8 latched data", d, 8'h77);
    chk("R8 ibf cleared", {7'd0, pc_out[5]}, 8'h00);
    chk("R9 intr A cleared", {7'd0, pc_out[3]}, 8'h00);
    bus_wr(2'd3, 8'h08);
    pulse_pc(4);
    chk("R9 no intr without enable", {7'd0, pc_out[3]}, 8'h00);

    // Group A strobed output
    bus_wr(2'd3, 8'hA0);
    chk("R13 A out pc_oe", pc_oe, 8'hBF);
    chk("R10 obf idle", {7'd0, pc_out[7]}, 8'h01);
    bus_wr(2'd3, 8'h0D);
    bus_wr(2'd0, 8'h42);
    chk("R10 pa_out", pa_out, 8'h42);
    chk("R10 obf low", {7'd0, pc_out[7]}, 8'h00);
    pulse_pc(6);
    chk("R10 obf released", {7'd0, pc_out[7]}, 8'h01);
    chk("R9 intr A on ack", {7'd0, pc_out[3]}, 8'h01);
    bus_wr(2'd0, 8'h43);
    chk("R10 intr cleared by write", {7'd0, pc_out[3]}, 8'h00);

    // Group B strobed input
    bus_wr(2'd3, 8'h86);
    chk("R13 B pc_oe", pc_oe, 8'hFB);
    bus_wr(2'd3, 8'h05);
    pb_in = 8'h99;
    pulse_pc(2);
    pb_in = 8'h00;
    chk("R11 ibf B", {7'd0, pc_out[1]}, 8'h01);
    chk("R9 intr B", {7'd0, pc_out[0]}, 8'h01);
    bus_rd(2'd1, d, oe);
    chk("R11 latched B", d, 8'h99);
    chk("R11 flags cleared", {6'd0, pc_out[1], pc_out[0]}, 8'h00);

    // Bidirectional request falls back
    bus_wr(2'd3, 8'hC0);
    chk("R12 flag", {7'd0, mode2_flag}, 8'h01);
    bus_wr(2'd0, 8'h3C);
    chk("R12 A simple out", pa_out, 8'h3C);
    chk("R12 A oe", pa_oe, 8'hFF);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule